// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet port and decides whether a frame is kept, using nothing but its 48-bit destination address. It watches a byte-wide receive stream, collects the first six bytes after a start-of-frame strobe and then gives a single verdict. The verdict says whether the frame is accepted and why: an exact hit (with the index of the entry that hit), a multicast hash hit, a broadcast address, or copy-all mode.

Software sets the filter through a plain word-wide register write port. There is a bank of exact-match entries, where entry 0 is meant for the station's own address. There is also a 64-bit multicast hash table and a small mode register. The hash index is not a CRC. It is a 6-bit XOR fold of all 48 address bits. Each exact entry is armed by writing its high word and disarmed by writing its low word. Software can therefore rewrite an entry and no frame is ever compared against a half-updated address.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `vd_valid` is low, every exact entry is disarmed, both hash words are zero and all mode bits are clear. In this state, a unicast frame is rejected and a broadcast frame is accepted.
- R2: Exact entry i uses two registers. The low word at byte offset 8*i holds address bytes 3,2,1,0 in bits 31:24, 23:16, 15:8 and 7:0. The high word at offset 8*i+4 holds byte 5 in bits 15:8 and byte 4 in bits 7:0. Byte 0 is the first byte on the stream. An armed entry equal to the address gives accept, `vd_exact`=1 and `vd_index`=i.
- R3: Writing an entry's low word disarms that entry. Writing its high word arms it.
- R4: When several armed entries match, `vd_index` reports the lowest matching index. With no exact hit, `vd_index` is 0.
- R5: The hash index h is computed as follows. Take address bit k, which is bit k%8 of byte k/8, for k = 0..47. XOR each bit into index bit k mod 6. Table bit h is bit h of the word at offset 0x40 for h<32, and bit h-32 of the word at 0x44 otherwise. A group frame is accepted through the hash when hashing is enabled and the selected bit is 1. A frame whose selected bit is 0 and that has no other hit is rejected.
- R6: Only a frame whose group bit (bit 0 of byte 0) is 1 takes part in the hash lookup. The lookup is gated by mode bit 2 (hash enable). A unicast frame never gives `vd_hash`.
- R7: The all-ones address raises `vd_bcast`. It is accepted unless mode bit 1 (broadcast reject) is set. When that bit is set, the broadcast frame is rejected even if an exact entry holds all ones. A broadcast frame never gives `vd_hash`.
- R8: Mode bit 0 (copy all) makes every frame accepted and raises `vd_promisc`.
- R9: `vd_valid` is a one-cycle pulse. It is high in the cycle after the clock edge that takes the sixth address byte. Cycles with `rx_valid` low within the header are skipped. Bytes after the sixth give no further verdict until the next start of frame.
- R10: `rx_sof` together with `rx_valid` always starts a new capture at byte 0. This also applies in the middle of a header, and the partial header is discarded.
- R11: The mode register is at offset 0x48. A write to any other offset is ignored; this covers offset 0x4C and word offsets that are not aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame (qualified by rx_valid) |
| rx_data | input | 8 | Receive byte |
| vd_valid | output | 1 | Verdict pulse |
| vd_accept | output | 1 | Frame accepted |
| vd_index | output | 3 | Lowest matching exact entry |
| vd_exact | output | 1 | Exact entry hit |
| vd_hash | output | 1 | Multicast hash hit |
| vd_bcast | output | 1 | Destination is broadcast |
| vd_promisc | output | 1 | Copy-all mode was on |

## Verification
The bench builds the block with its default values: eight exact entries and an 8-bit register offset. With these values, both ends of the entry bank can be reached. An address is loaded into entries 0 and 6 at once, so the lowest-index priority shows up, and disarming entry 0 exposes entry 6. Hash addresses are chosen with hand-computed fold indices 22 and 58, so both halves of the table are used. A unicast address with the same fold as a programmed group address shows that the group bit gates the lookup.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int MAC_W      = 8 * ADDR_BYTES;
  localparam int HASH_W     = 6;
  localparam int HASH_N     = 1 << HASH_W;

  typedef logic [MAC_W-1:0] mac_t;

  // mode register layout, bit 2 down to bit 0
  typedef struct packed {
    logic hash_en;
    logic bc_reject;
    logic copy_all;
  } rxf_mode_t;

  // XOR fold: address bit k lands in index bit k mod HASH_W
  function automatic logic [HASH_W-1:0] fold_index(input mac_t a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int k = 0; k < MAC_W; k++) h[k % HASH_W] ^= a[k];
    return h;
  endfunction
endpackage

// File: rtl/rxf_regbank.sv
module rxf_regbank
  import rxf_pkg::*;
#(
  parameter int NUM_FILT = 8,
  parameter int RA_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [RA_W-1:0]               addr,
  input  logic [31:0]                   wdata,
  output logic [NUM_FILT-1:0][MAC_W-1:0] filt_addr,
  output logic [NUM_FILT-1:0]           filt_en,
  output logic [HASH_N-1:0]             hash_tbl,
  output rxf_mode_t                     mode
);
  localparam int HASH_LO_A = 8 * NUM_FILT;
  localparam int HASH_HI_A = HASH_LO_A + 4;
  localparam int MODE_A    = HASH_LO_A + 8;

  logic wr_hlo, wr_hhi, wr_mode;
  logic [31:0] hlo_q, hhi_q;
  rxf_mode_t   mode_q;

  assign wr_hlo  = we && (addr == RA_W'(HASH_LO_A));
  assign wr_hhi  = we && (addr == RA_W'(HASH_HI_A));
  assign wr_mode = we && (addr == RA_W'(MODE_A));

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_ent
    logic        wr_lo, wr_hi, en_d, en_q;
    logic [31:0] lo_q;
    logic [15:0] hi_q;

    assign wr_lo = we && (addr == RA_W'(8 * i));
    assign wr_hi = we && (addr == RA_W'(8 * i + 4));

    always_comb begin
      en_d = en_q;
      if (wr_lo)      en_d = 1'b0;
      else if (wr_hi) en_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
        en_q <= 1'b0;
      end else begin
        if (wr_lo) lo_q <= wdata;
        if (wr_hi) hi_q <= wdata[15:0];
        en_q <= en_d;
      end
    end

    assign filt_addr[i] = {hi_q, lo_q};
    assign filt_en[i]   = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hlo_q  <= '0;
      hhi_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_hlo)  hlo_q  <= wdata;
      if (wr_hhi)  hhi_q  <= wdata;
      if (wr_mode) mode_q <= rxf_mode_t'(wdata[2:0]);
    end
  end

  assign hash_tbl = {hhi_q, hlo_q};
  assign mode     = mode_q;
endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic [7:0] rx_data,
  output mac_t       addr_nxt,
  output logic       done_nxt
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, slot;
  mac_t             addr_q;
  logic             store;

  always_comb begin
    slot     = rx_sof ? '0 : cnt_q;
    store    = rx_valid && (rx_sof || (cnt_q != IDLE));
    addr_nxt = addr_q;
    for (int b = 0; b < ADDR_BYTES; b++)
      if (store && (slot == CNT_W'(b))) addr_nxt[8*b +: 8] = rx_data;
    cnt_d    = store ? slot + CNT_W'(1) : cnt_q;
    done_nxt = store && (slot == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= IDLE;
      addr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (store) addr_q <= addr_nxt;
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int NUM_FILT = 8,
  localparam int IDX_W   = $clog2(NUM_FILT)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  mac_t                           addr_nxt,
  input  logic                           done_nxt,
  input  logic [NUM_FILT-1:0][MAC_W-1:0] filt_addr,
  input  logic [NUM_FILT-1:0]            filt_en,
  input  logic [HASH_N-1:0]              hash_tbl,
  input  rxf_mode_t                      mode,
  output logic                           vd_valid,
  output logic                           vd_accept,
  output logic [IDX_W-1:0]               vd_index,
  output logic                           vd_exact,
  output logic                           vd_hash,
  output logic                           vd_bcast,
  output logic                           vd_promisc
);
  logic [NUM_FILT-1:0] hit;
  logic [IDX_W-1:0]    idx_d;
  logic [HASH_W-1:0]   hidx;
  logic                is_bc, exact_d, hash_d, acc_d;

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_cmp
    assign hit[i] = filt_en[i] && (filt_addr[i] == addr_nxt);
  end

  always_comb begin
    idx_d = '0;
    for (int i = NUM_FILT - 1; i >= 0; i--)
      if (hit[i]) idx_d = IDX_W'(i);
    is_bc   = &addr_nxt;
    hidx    = fold_index(addr_nxt);
    exact_d = |hit;
    hash_d  = mode.hash_en && addr_nxt[0] && !is_bc && hash_tbl[hidx];
    acc_d   = mode.copy_all || (is_bc ? !mode.bc_reject : (exact_d || hash_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_valid   <= 1'b0;
      vd_accept  <= 1'b0;
      vd_index   <= '0;
      vd_exact   <= 1'b0;
      vd_hash    <= 1'b0;
      vd_bcast   <= 1'b0;
      vd_promisc <= 1'b0;
    end else begin
      vd_valid <= done_nxt;
      if (done_nxt) begin
        vd_accept  <= acc_d;
        vd_index   <= idx_d;
        vd_exact   <= exact_d;
        vd_hash    <= hash_d;
        vd_bcast   <= is_bc;
        vd_promisc <= mode.copy_all;
      end
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int NUM_FILT = 8,
  parameter int RA_W     = 8,
  localparam int IDX_W   = $clog2(NUM_FILT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [7:0]       rx_data,
  output logic             vd_valid,
  output logic             vd_accept,
  output logic [IDX_W-1:0] vd_index,
  output logic             vd_exact,
  output logic             vd_hash,
  output logic             vd_bcast,
  output logic             vd_promisc
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_FILT-1:0][MAC_W-1:0] filt_addr;
  logic [NUM_FILT-1:0]            filt_en;
  logic [HASH_N-1:0]              hash_tbl;
  rxf_mode_t                      mode;
  mac_t                           addr_nxt;
  logic                           done_nxt;

  rxf_regbank #(.NUM_FILT(NUM_FILT), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .filt_addr(filt_addr), .filt_en(filt_en), .hash_tbl(hash_tbl), .mode(mode)
  );

  rxf_capture u_cap (
    .clk(clk), .rst_n(rst_int_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .addr_nxt(addr_nxt), .done_nxt(done_nxt)
  );

  rxf_decide #(.NUM_FILT(NUM_FILT)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .addr_nxt(addr_nxt), .done_nxt(done_nxt),
    .filt_addr(filt_addr), .filt_en(filt_en), .hash_tbl(hash_tbl), .mode(mode),
    .vd_valid(vd_valid), .vd_accept(vd_accept), .vd_index(vd_index),
    .vd_exact(vd_exact), .vd_hash(vd_hash), .vd_bcast(vd_bcast),
    .vd_promisc(vd_promisc)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             vd_valid,
  input logic             vd_accept,
  input logic [IDX_W-1:0] vd_index,
  input logic             vd_exact,
  input logic             vd_hash,
  input logic             vd_bcast,
  input logic             vd_promisc
);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |=> !vd_valid);

  p_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |-> $past(rx_valid));

  p_exact_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_exact && !vd_bcast) |-> vd_accept);

  p_index_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && !vd_exact) |-> (vd_index == '0));

  p_no_hit_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && !vd_promisc && !vd_bcast && !vd_exact && !vd_hash) |-> !vd_accept);

  p_hash_not_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_hash) |-> !vd_bcast);

  p_copy_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_promisc) |-> vd_accept);
endmodule

bind rx_dest_filter rxf_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .vd_valid(vd_valid),
  .vd_accept(vd_accept), .vd_index(vd_index), .vd_exact(vd_exact),
  .vd_hash(vd_hash), .vd_bcast(vd_bcast), .vd_promisc(vd_promisc)
);

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        vd_valid, vd_accept, vd_exact, vd_hash, vd_bcast, vd_promisc;
  logic [2:0]  vd_index;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .vd_valid(vd_valid), .vd_accept(vd_accept), .vd_index(vd_index),
    .vd_exact(vd_exact), .vd_hash(vd_hash), .vd_bcast(vd_bcast),
    .vd_promisc(vd_promisc)
  );

  localparam logic [47:0] A_STN  = 48'h554433221100; // bytes 00 11 22 33 44 55
  localparam logic [47:0] A_MC3  = 48'h0100005e0001; // fold 38
  localparam logic [47:0] A_G1   = 48'h0e0000c28001; // fold 58
  localparam logic [47:0] A_G2   = 48'h0200005e0001; // fold 22
  localparam logic [47:0] A_G3   = 48'h000000000003; // fold 3
  localparam logic [47:0] A_UNI  = 48'h564433221100;
  localparam logic [47:0] A_UF22 = 48'h0200005e0040; // unicast, fold 22
  localparam logic [47:0] A_BC   = 48'hffffffffffff;

  // {addr, accept, exact, hash, bcast, index}
  localparam logic [54:0] VECS [8] = '{
    {A_STN,  1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    {A_MC3,  1'b1, 1'b1, 1'b0, 1'b0, 3'd3},
    {A_G1,   1'b1, 1'b0, 1'b1, 1'b0, 3'd0},
    {A_G2,   1'b1, 1'b0, 1'b1, 1'b0, 3'd0},
    {A_G3,   1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    {A_UNI,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    {A_UF22, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    {A_BC,   1'b1, 1'b0, 1'b0, 1'b1, 3'd0}
  };
  localparam string VTAG [8] = '{"R2 R4", "R2", "R5", "R5", "R5", "R6", "R6", "R7"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load_entry(input int i, input logic [47:0] a);
    wr(8'(8 * i), a[31:0]);
    wr(8'(8 * i + 4), {16'h0, a[47:32]});
  endtask

  // drives six bytes back to back; returns at the negedge after the last
  task automatic send(input logic [47:0] a);
    for (int i = 0; i < 6; i++) begin
      rx_sof = (i == 0); rx_valid = 1'b1; rx_data = a[8*i +: 8];
      @(negedge clk);
    end
    rx_sof = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic check_vd(input string req, input logic acc, input logic ex,
                          input logic hs, input logic bc, input logic pr,
                          input logic [2:0] idx);
    if (acc == 1'b0 && ex == 1'b0) idx = 3'd0;
    check(req, {55'h0, vd_valid, vd_accept, vd_exact, vd_hash, vd_bcast, vd_promisc, vd_index},
               {55'h0, 1'b1, acc, ex, hs, bc, pr, idx});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 valid in reset", 64'(vd_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after reset", 64'(vd_valid), 64'd0);

    // R1: nothing armed, hashing off
    send(A_STN);
    check_vd("R1 unicast rejected", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
    send(A_BC);
    check_vd("R1 broadcast accepted", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    send(A_G2);
    check_vd("R1 hash empty", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);

    // program: entries 0,3,6; hash bits 22 and 58; hash enable
    load_entry(0, A_STN);
    load_entry(3, A_MC3);
    load_entry(6, A_STN);
    wr(8'h40, 32'h0040_0000);
    wr(8'h44, 32'h0400_0000);
    wr(8'h48, 32'h4);

    for (int v = 0; v < 8; v++) begin
      send(VECS[v][54:7]);
      check_vd(VTAG[v], VECS[v][6], VECS[v][5], VECS[v][4], VECS[v][3], 1'b0, VECS[v][2:0]);
    end

    // R3: disarm / rearm through word order
    wr(8'h00, A_STN[31:0]);
    send(A_STN);
    check_vd("R3 low write disarms 0", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6);
    wr(8'h30, A_STN[31:0]);
    send(A_STN);
    check_vd("R3 both disarmed", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
    wr(8'h34, {16'h0, A_STN[47:32]});
    send(A_STN);
    check_vd("R3 R4 high write arms 6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6);
    wr(8'h04, {16'h0, A_STN[47:32]});
    send(A_STN);
    check_vd("R3 R4 rearmed 0 wins", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);

    // R7: broadcast reject, also against an all-ones exact entry
    wr(8'h48, 32'h6);
    load_entry(7, A_BC);
    send(A_BC);
    check_vd("R7 broadcast rejected", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd7);
    check("R7 index on rejected bcast", 64'(vd_index), 64'd7);
    wr(8'h38, 32'hffff_ffff);

    // R8: copy all
    wr(8'h48, 32'h7);
    send(A_BC);
    check_vd("R8 copy all over bcast reject", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    send(A_UNI);
    check_vd("R8 copy all unicast", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0);

    // R6: hash disabled
    wr(8'h48, 32'h0);
    send(A_G1);
    check_vd("R6 hash gated off", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);

    // R11: stray writes ignored
    wr(8'h4c, 32'hffff_ffff);
    wr(8'h02, 32'hffff_ffff);
    wr(8'h49, 32'hffff_ffff);
    send(A_UNI);
    check_vd("R11 mode unchanged", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
    send(A_STN);
    check_vd("R11 entry unchanged", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);

    // R9: gaps inside header, pulse timing, trailing bytes
    for (int i = 0; i < 6; i++) begin
      rx_sof = (i == 0); rx_valid = 1'b1; rx_data = A_MC3[8*i +: 8];
      if (i == 5) check("R9 no verdict before 6th byte", 64'(vd_valid), 64'd0);
      @(negedge clk);
      rx_sof = 1'b0;
      if (i < 5) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
    end
    rx_valid = 1'b0;
    check_vd("R9 verdict after gaps", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3);
    @(negedge clk);
    check("R9 one-cycle pulse", 64'(vd_valid), 64'd0);
    for (int i = 0; i < 8; i++) begin
      rx_valid = 1'b1; rx_data = 8'hff;
      @(negedge clk);
      check("R9 trailing bytes ignored", 64'(vd_valid), 64'd0);
    end
    rx_valid = 1'b0;

    // R10: restart mid-header
    for (int i = 0; i < 3; i++) begin
      rx_sof = (i == 0); rx_valid = 1'b1; rx_data = A_UNI[8*i +: 8];
      @(negedge clk);
    end
    send(A_STN);
    check_vd("R10 restart captures new address", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    check("R10 single verdict", 64'(vd_valid), 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule